// File: doc/BRIEF.md
# Pending Interrupt Priority Selector

This block sits in front of a processor's exception entry logic and holds the asynchronous interrupt requests that have not yet been serviced. Event sources such as timers, doorbells and the monitor request are latched from one-cycle set pulses. The two external request lines are level sources: their pending bits follow the lines and are not consumed by being taken. A fixed priority order, arranged in tiers, selects at most one source. Each tier is gated by its own enable condition taken from the current machine state.

Selection is purely combinational from the registered pending vector and the machine-state enables. The result is a valid flag and an exception code for the entry logic. When the entry logic asserts its service request while the flag is high, the chosen event source is retired on that clock edge. All other sources stay pending for later requests.

Source indices, from highest to lowest priority: 0 reset, 1 machine check, 2 hypervisor decrementer, 3 critical external (level), 4 watchdog, 5 critical doorbell, 6 fixed-interval timer, 7 programmable interval timer, 8 decrementer, 9 external (level), 10 doorbell, 11 performance monitor, 12 thermal. The exception code is the source index plus one. Code 0 means "none".

Top module: `pirq_sel_top`

## Requirements
- R1: In the cycle after synchronous reset, the pending vector is all zero, the valid flag is low and the code is 0.
- R2: A set pulse on an event source index makes that bit of the pending vector 1 after the next clock edge. The pending bits at indices 3 and 9 equal the critical external and external lines sampled at the previous edge.
- R3: Reset (index 0, code 1) outranks everything and machine check (index 1, code 2) comes next. Neither depends on any enable input.
- R4: The hypervisor decrementer (index 2, code 3) qualifies only when its enable is 1 and at least one of these holds: external-enable is 1, hypervisor is 0, or problem-state is 1.
- R5: Critical external (index 3, code 4) qualifies only when critical-enable is 1.
- R6: Indices 4 to 12 qualify only when external-enable is 1. Among them the lower index wins.
- R7: A service request with valid high retires only the chosen source. The chosen event bit reads 0 after the edge, and every other pending bit is unaffected.
- R8: External and critical external stay pending after being taken for as long as their lines remain high.
- R9: A set pulse and a retirement of the same event bit in the same cycle leave the bit set.
- R10: When no source qualifies, valid is 0 and the code is 0. When valid is 1, the code is nonzero.
- R11: Without a service request, no pending event bit is cleared.
- R12: Set pulses at the level-source indices 3 and 9 have no effect on the pending vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_pulse | input | 13 | Per-source one-cycle set request, indexed by source |
| ext_lvl | input | 1 | External request line (level) |
| cext_lvl | input | 1 | Critical external request line (level) |
| crit_en | input | 1 | Critical-tier enable |
| ext_en | input | 1 | External-tier enable |
| hyp_mode | input | 1 | Hypervisor state bit |
| prob_mode | input | 1 | Problem (user) state bit |
| hdec_en | input | 1 | Hypervisor decrementer enable |
| svc_req | input | 1 | Entry logic takes the selected interrupt on this edge |
| take_vld | output | 1 | A source qualifies |
| take_code | output | 4 | Selected exception code, 0 when none |
| pend | output | 13 | Registered pending vector |

## Verification
Two functions can fall on the same edge: retirement of the selected event source and a fresh set pulse for that same source. The bench pends the decrementer with external-enable high. It then asserts the service request together with a new decrementer pulse, and checks that the pending bit still reads 1 and the code is still the decrementer's. A second case drives the external line while requests repeat. Each cycle, the code must stay the external code and the bit must stay pending. The bit must drop only one edge after the line falls.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int NSRC   = 13;
    localparam int CODE_W = 4;
    localparam int IDX_W  = $clog2(NSRC);

    localparam int IX_RESET = 0;
    localparam int IX_MCHK  = 1;
    localparam int IX_HDEC  = 2;
    localparam int IX_CEXT  = 3;
    localparam int IX_WDOG  = 4;
    localparam int IX_CDB   = 5;
    localparam int IX_FIT   = 6;
    localparam int IX_PIT   = 7;
    localparam int IX_DEC   = 8;
    localparam int IX_EXT   = 9;
    localparam int IX_DB    = 10;
    localparam int IX_PERF  = 11;
    localparam int IX_THERM = 12;

    typedef enum logic [CODE_W-1:0] {
        XC_NONE  = 4'd0,
        XC_RESET = 4'd1,
        XC_MCHK  = 4'd2,
        XC_HDEC  = 4'd3,
        XC_CEXT  = 4'd4,
        XC_WDOG  = 4'd5,
        XC_CDB   = 4'd6,
        XC_FIT   = 4'd7,
        XC_PIT   = 4'd8,
        XC_DEC   = 4'd9,
        XC_EXT   = 4'd10,
        XC_DB    = 4'd11,
        XC_PERF  = 4'd12,
        XC_THERM = 4'd13
    } xcode_e;

    // Machine-state enables that gate the tiers
    typedef struct packed {
        logic crit;
        logic ext;
        logic hyp;
        logic prob;
        logic hdec;
    } tier_ctl_t;

    // Sources whose pending bit tracks a line instead of a latched event
    localparam logic [NSRC-1:0] LEVEL_MASK =
        NSRC'((1 << IX_CEXT) | (1 << IX_EXT));

    // Tier membership
    localparam logic [NSRC-1:0] UNGATED_MASK =
        NSRC'((1 << IX_RESET) | (1 << IX_MCHK));
    localparam logic [NSRC-1:0] EE_TIER_MASK =
        NSRC'(((1 << NSRC) - 1) & ~((1 << (IX_CEXT + 1)) - 1));

    function automatic xcode_e code_of_idx(input logic [IDX_W-1:0] idx);
        return xcode_e'(CODE_W'(idx) + CODE_W'(1));
    endfunction

    function automatic logic hdec_gate(input tier_ctl_t c);
        return c.hdec & (c.ext | ~c.hyp | c.prob);
    endfunction

endpackage

// File: rtl/pirq_pend_store.sv
module pirq_pend_store
    import pirq_pkg::*;
#(
    parameter int              N        = NSRC,
    parameter logic [N-1:0]    LVL_MASK = LEVEL_MASK
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_pulse,
    input  logic [N-1:0] lvl_in,
    input  logic [N-1:0] retire,
    output logic [N-1:0] pend_q
);

    logic [N-1:0] pend_d;

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (LVL_MASK[i]) begin : g_level
            // level source: follows its line, taking has no effect
            assign pend_d[i] = lvl_in[i];
        end else begin : g_event
            // latched event: set beats retire
            assign pend_d[i] = set_pulse[i] | (pend_q[i] & ~retire[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

endmodule

// File: rtl/pirq_qualify.sv
module pirq_qualify
    import pirq_pkg::*;
#(
    parameter int           N       = NSRC,
    parameter logic [N-1:0] FREE_M  = UNGATED_MASK,
    parameter logic [N-1:0] EE_M    = EE_TIER_MASK,
    parameter int           HDEC_IX = IX_HDEC,
    parameter int           CEXT_IX = IX_CEXT
) (
    input  logic [N-1:0] pend,
    input  tier_ctl_t    ctl,
    output logic [N-1:0] elig
);

    logic [N-1:0] allow;

    for (genvar i = 0; i < N; i++) begin : g_allow
        if (FREE_M[i]) begin : g_free
            assign allow[i] = 1'b1;
        end else if (i == HDEC_IX) begin : g_hdec
            assign allow[i] = hdec_gate(ctl);
        end else if (i == CEXT_IX) begin : g_crit
            assign allow[i] = ctl.crit;
        end else if (EE_M[i]) begin : g_ee
            assign allow[i] = ctl.ext;
        end else begin : g_off
            assign allow[i] = 1'b0;
        end
    end

    assign elig = pend & allow;

endmodule

// File: rtl/pirq_prio_pick.sv
module pirq_prio_pick #(
    parameter int N     = 13,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     elig,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] grant_idx,
    output logic             any
);

    // blk[i] is high when some lower index (higher priority) is eligible
    logic [N:0] blk;
    assign blk[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i]  = elig[i] & ~blk[i];
        assign blk[i+1]  = blk[i] | elig[i];
    end

    assign any = blk[N];

    always_comb begin
        grant_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) begin
                grant_idx = grant_idx | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/pirq_sel_top.sv
module pirq_sel_top
    import pirq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        set_pulse,
    input  logic                ext_lvl,
    input  logic                cext_lvl,
    input  logic                crit_en,
    input  logic                ext_en,
    input  logic                hyp_mode,
    input  logic                prob_mode,
    input  logic                hdec_en,
    input  logic                svc_req,
    output logic                take_vld,
    output logic [CODE_W-1:0]   take_code,
    output logic [N-1:0]        pend
);

    localparam int IW = $clog2(N);

    tier_ctl_t      ctl;
    logic [N-1:0]   lvl_vec;
    logic [N-1:0]   elig;
    logic [N-1:0]   grant;
    logic [N-1:0]   retire;
    logic [IW-1:0]  gidx;
    logic           any;
    xcode_e         code;

    assign ctl = '{crit: crit_en, ext: ext_en, hyp: hyp_mode,
                   prob: prob_mode, hdec: hdec_en};

    always_comb begin
        lvl_vec          = '0;
        lvl_vec[IX_EXT]  = ext_lvl;
        lvl_vec[IX_CEXT] = cext_lvl;
    end

    pirq_pend_store #(.N(N), .LVL_MASK(LEVEL_MASK)) u_store (
        .clk       (clk),
        .rst       (rst),
        .set_pulse (set_pulse),
        .lvl_in    (lvl_vec),
        .retire    (retire),
        .pend_q    (pend)
    );

    pirq_qualify #(.N(N)) u_qual (
        .pend (pend),
        .ctl  (ctl),
        .elig (elig)
    );

    pirq_prio_pick #(.N(N), .IDX_W(IW)) u_pick (
        .elig      (elig),
        .grant     (grant),
        .grant_idx (gidx),
        .any       (any)
    );

    assign retire    = grant & {N{svc_req & any}};
    assign code      = any ? code_of_idx(gidx) : XC_NONE;
    assign take_vld  = any;
    assign take_code = code;

endmodule

// File: rtl/pirq_sel_chk.sv
module pirq_sel_chk
    import pirq_pkg::*;
#(
    parameter int N = NSRC
) (
    input logic              clk,
    input logic              rst,
    input logic [N-1:0]      set_pulse,
    input logic              ext_lvl,
    input logic              cext_lvl,
    input logic              crit_en,
    input logic              ext_en,
    input logic              hyp_mode,
    input logic              prob_mode,
    input logic              hdec_en,
    input logic              svc_req,
    input logic              take_vld,
    input logic [CODE_W-1:0] take_code,
    input logic [N-1:0]      pend
);

    localparam logic [N-1:0] EVT = ~LEVEL_MASK;

    AST_RESET_CLEAN: assert property (@(posedge clk)
        $fell(rst) |-> (pend == '0 && !take_vld && take_code == '0)); // R1

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
        (|(set_pulse & EVT)) |=> ((pend & $past(set_pulse & EVT)) == $past(set_pulse & EVT))); // R2

    AST_RESET_FIRST: assert property (@(posedge clk) disable iff (rst)
        pend[IX_RESET] |-> (take_vld && take_code == XC_RESET)); // R3

    AST_MCHK_SECOND: assert property (@(posedge clk) disable iff (rst)
        (pend[IX_MCHK] && !pend[IX_RESET]) |-> (take_code == XC_MCHK)); // R3

    AST_HDEC_GATE: assert property (@(posedge clk) disable iff (rst)
        (take_code == XC_HDEC) |-> (hdec_en && (ext_en || !hyp_mode || prob_mode))); // R4

    AST_CRIT_GATE: assert property (@(posedge clk) disable iff (rst)
        (take_code == XC_CEXT) |-> crit_en); // R5

    AST_EE_GATE: assert property (@(posedge clk) disable iff (rst)
        (take_code >= XC_WDOG) |-> ext_en); // R6

    AST_RETIRE_EVENT: assert property (@(posedge clk) disable iff (rst)
        (svc_req && take_vld && !LEVEL_MASK[int'(take_code) - 1]
         && !set_pulse[int'(take_code) - 1])
        |=> !pend[int'($past(take_code)) - 1]); // R7

    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (pend[IX_EXT] == $past(ext_lvl) && pend[IX_CEXT] == $past(cext_lvl))); // R8

    AST_VALID_CODE: assert property (@(posedge clk) disable iff (rst)
        take_vld == (take_code != '0)); // R10

    AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (!svc_req) |=> ((($past(pend) & EVT) & ~pend) == '0)); // R11

endmodule

bind pirq_sel_top pirq_sel_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .set_pulse (set_pulse),
    .ext_lvl   (ext_lvl),
    .cext_lvl  (cext_lvl),
    .crit_en   (crit_en),
    .ext_en    (ext_en),
    .hyp_mode  (hyp_mode),
    .prob_mode (prob_mode),
    .hdec_en   (hdec_en),
    .svc_req   (svc_req),
    .take_vld  (take_vld),
    .take_code (take_code),
    .pend      (pend)
);

// File: tb/tb_pirq_sel_top.sv
module tb_pirq_sel_top;

    localparam int N = 13;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  set_pulse = '0;
    logic          ext_lvl = 1'b0, cext_lvl = 1'b0;
    logic          crit_en = 1'b0, ext_en = 1'b0, hyp_mode = 1'b0;
    logic          prob_mode = 1'b0, hdec_en = 1'b0, svc_req = 1'b0;
    logic          take_vld;
    logic [3:0]    take_code;
    logic [N-1:0]  pend;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pirq_sel_top dut (
        .clk(clk), .rst(rst), .set_pulse(set_pulse),
        .ext_lvl(ext_lvl), .cext_lvl(cext_lvl),
        .crit_en(crit_en), .ext_en(ext_en), .hyp_mode(hyp_mode),
        .prob_mode(prob_mode), .hdec_en(hdec_en), .svc_req(svc_req),
        .take_vld(take_vld), .take_code(take_code), .pend(pend)
    );

    // {pulse mask[23:11], ext, cext, crit, ee, hyp, prob, hdec, expected code[3:0]}
    localparam logic [23:0] VECS [17] = '{
        {13'h1FFF, 7'b0000000, 4'd1},
        {13'h1FFE, 7'b0000000, 4'd2},
        {13'h0014, 7'b0000101, 4'd0},
        {13'h0014, 7'b0000111, 4'd3},
        {13'h0014, 7'b0000001, 4'd3},
        {13'h0014, 7'b0001100, 4'd5},
        {13'h0000, 7'b0100000, 4'd0},
        {13'h0000, 7'b0110000, 4'd4},
        {13'h05C0, 7'b0001000, 4'd7},
        {13'h1D00, 7'b0001000, 4'd9},
        {13'h0400, 7'b1001000, 4'd10},
        {13'h1800, 7'b0001000, 4'd12},
        {13'h1000, 7'b0001000, 4'd13},
        {13'h1000, 7'b0000000, 4'd0},
        {13'h0060, 7'b0001000, 4'd6},
        {13'h0180, 7'b0001000, 4'd8},
        {13'h0004, 7'b0001101, 4'd3}
    };

    localparam logic [N-1:0] LVLM = 13'h0208;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; set_pulse = '0; svc_req = 1'b0;
        ext_lvl = 1'b0; cext_lvl = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        set_pulse = m;
        @(negedge clk);
        set_pulse = '0;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 pend", 32'(pend), 0);
        chk("R1 vld", 32'(take_vld), 0);
        chk("R1 code", 32'(take_code), 0);

        // table: R2 pend capture, R3/R4/R5/R6 priority and gating, R10 none
        foreach (VECS[k]) begin
            logic [N-1:0] m;
            logic [N-1:0] ep;
            do_reset();
            m = VECS[k][23:11];
            {ext_lvl, cext_lvl, crit_en, ext_en, hyp_mode, prob_mode, hdec_en} = VECS[k][10:4];
            pulse(m);
            ep = (m & ~LVLM) | (N'(ext_lvl) << 9) | (N'(cext_lvl) << 3);
            chk($sformatf("R2 vec%0d pend", k), 32'(pend), 32'(ep));
            chk($sformatf("R3/R4/R5/R6 vec%0d code", k), 32'(take_code), 32'(VECS[k][3:0]));
            chk($sformatf("R10 vec%0d vld", k), 32'(take_vld), 32'(VECS[k][3:0] != 0));
        end

        // R7 drain: one per request, in order
        do_reset();
        crit_en = 0; ext_en = 1; hyp_mode = 0; prob_mode = 0; hdec_en = 0;
        pulse(13'h0150); // WDOG, FIT, DEC
        svc_req = 1'b1;
        chk("R7 first", 32'(take_code), 5);
        @(negedge clk);
        chk("R7 second", 32'(take_code), 7);
        chk("R7 pend after one", 32'(pend), 32'h0140);
        @(negedge clk);
        chk("R7 third", 32'(take_code), 9);
        @(negedge clk);
        chk("R7 drained code", 32'(take_code), 0);
        chk("R7 drained pend", 32'(pend), 0);
        svc_req = 1'b0;

        // R8 level source stays pending while taken
        do_reset();
        ext_en = 1; ext_lvl = 1;
        @(negedge clk);
        svc_req = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R8 ext code", 32'(take_code), 10);
            chk("R8 ext pend", 32'(pend[9]), 1);
        end
        ext_lvl = 0;
        @(negedge clk);
        chk("R8 ext released", 32'(pend[9]), 0);
        svc_req = 1'b0;

        // R9 set and retire on the same edge
        do_reset();
        ext_en = 1;
        pulse(13'h0100);
        chk("R9 pre", 32'(take_code), 9);
        svc_req = 1'b1; set_pulse = 13'h0100;
        @(negedge clk);
        set_pulse = '0; svc_req = 1'b0;
        chk("R9 bit kept", 32'(pend[8]), 1);
        chk("R9 code kept", 32'(take_code), 9);

        // R11 no request keeps pending
        do_reset();
        ext_en = 1;
        pulse(13'h0010);
        repeat (4) @(negedge clk);
        chk("R11 kept", 32'(pend), 32'h0010);
        chk("R11 code", 32'(take_code), 5);

        // R12 pulses at level indices ignored
        do_reset();
        crit_en = 1; ext_en = 1;
        pulse(13'h0208);
        chk("R12 pend", 32'(pend), 0);
        chk("R12 vld", 32'(take_vld), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule